// File: doc/BRIEF.md
# Set-Clear-Toggle Register Bank

This block is a bank of 32-bit control registers reached through a simple memory-mapped port. Every register owns a 16-byte slot, and the word address inside that slot picks what a write does: replace the register, OR bits in, clear bits, or flip bits. Software can thus change single control bits without a read-modify-write sequence. Any of the four words of a slot reads back the register's current value.

The bank holds two groups. The first group, starting at byte offset 0x60, begins with clock-generator control registers that come out of reset with fixed values and with a lock-status flag forced on, so software sees every clock generator as locked; the rest of that group and a second group at offset 0x200 reset to zero. A read-only identification word at offset 0x800 takes priority over any group address it overlaps and ignores writes; an attempted write to it raises a one-cycle reject strobe. Addresses outside these areas, and accesses that are not word aligned, read as zero and ignore writes.

Top module: `sct_regbank`

## Requirements
- R1: After reset, slot k of the first group (byte address 0x60 + 16*k) reads, for k = 0..7: 0x80002042, 0x8060302C, 0x80002000, 0xD2605A56, 0xD2525216, 0x80001FC0, 0x8001301B, 0x8008201B, i.e. a fixed value with the lock flag (bit 31) ORed in.
- R2: After reset, slots 8..11 of the first group and all 8 slots of the second group (byte address 0x200 + 16*k) read zero.
- R3: A write with address bits [3:2] = 00 replaces the register with the write data, 01 ORs the data in, 10 clears the bits set in the data, and 11 XORs the data in.
- R4: A read at any of the four word addresses of a slot (address bits [3:2] any value) returns the register's current value.
- R5: The word at byte address 0x800 always reads 0x00720010; writes to it change nothing.
- R6: `id_wr_reject` is high for exactly the one cycle after a write request to 0x800 was accepted, and low otherwise.
- R7: An access with address bits [1:0] not zero, or to an address outside both groups and the identification word, reads zero and a write to it changes no register.
- R8: For a request accepted at a clock edge, `rd_valid` is high in the following cycle only for reads, `rd_data` then holds the read value, and a write is visible to a read issued in the next cycle.
- R9: The first group spans 12 slots (0x60 to 0x11F) and the second 8 slots (0x200 to 0x27F); the addresses just outside each span are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid, accepted at the rising edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address inside the 64 KB window |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after an accepted read |
| id_wr_reject | output | 1 | High the cycle after a write to the identification word |

## Verification
The assertions watch, on every cycle, the read-valid timing, the constant identification value, the reject strobe, zero data from unmapped or misaligned reads, and the set and clear aliases on the first clock register. The reset values, the assign and toggle aliases across all slots, alias-independent reads and the exact group boundaries are shown only by the bench, which runs directed corner cases and then a long seeded random mix of reads and writes checked against a bench model of the whole bank.

// File: rtl/sct_regbank.sv
module sct_regbank #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int ANA_BASE = 'h60,
  parameter int ANA_N = 12,
  parameter int CLK_N = 8,
  parameter int PMU_BASE = 'h200,
  parameter int PMU_N = 8,
  parameter int ID_ADDR = 'h800,
  parameter logic [31:0] ID_VALUE = 32'h0072_0010,
  parameter int LOCK_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          id_wr_reject
);
  localparam int SLOT = 16;
  localparam int ANA_END = ANA_BASE + ANA_N * SLOT;
  localparam int PMU_END = PMU_BASE + PMU_N * SLOT;
  localparam logic [DW-1:0] LOCK = DW'(1) << LOCK_BIT;

  function automatic logic [DW-1:0] clk_init(int k);
    case (k)
      0: return DW'(32'h0000_2042);
      1: return DW'(32'h0060_302C);
      2: return DW'(32'h0000_2000);
      3: return DW'(32'h5260_5A56);
      4: return DW'(32'h5252_5216);
      5: return DW'(32'h0000_1FC0);
      6: return DW'(32'h0001_301B);
      7: return DW'(32'h0008_201B);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] alias_op(logic [1:0] op, logic [DW-1:0] cur, logic [DW-1:0] wd);
    case (op)
      2'b00: return wd;
      2'b01: return cur | wd;
      2'b10: return cur & ~wd;
      default: return cur ^ wd;
    endcase
  endfunction

  logic [ANA_N-1:0][DW-1:0] ana_q;
  logic [PMU_N-1:0][DW-1:0] pmu_q;

  wire aligned = (bus_addr[1:0] == 2'b00);
  wire id_hit  = aligned && (bus_addr == AW'(ID_ADDR));
  wire ana_hit = aligned && !id_hit && (bus_addr >= AW'(ANA_BASE)) && (bus_addr < AW'(ANA_END));
  wire pmu_hit = aligned && !id_hit && (bus_addr >= AW'(PMU_BASE)) && (bus_addr < AW'(PMU_END));
  wire [AW-1:0] ana_off = bus_addr - AW'(ANA_BASE);
  wire [AW-1:0] pmu_off = bus_addr - AW'(PMU_BASE);
  wire [1:0] op = bus_addr[3:2];
  wire wr = bus_valid && bus_write;
  wire rd = bus_valid && !bus_write;

  for (genvar k = 0; k < ANA_N; k++) begin : g_ana
    localparam logic [DW-1:0] RST = (k < CLK_N) ? (clk_init(k) | LOCK) : '0;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ana_q[k] <= RST;
      else if (wr && ana_hit && ana_off[AW-1:4] == (AW-4)'(k))
        ana_q[k] <= alias_op(op, ana_q[k], bus_wdata);
  end

  for (genvar k = 0; k < PMU_N; k++) begin : g_pmu
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pmu_q[k] <= '0;
      else if (wr && pmu_hit && pmu_off[AW-1:4] == (AW-4)'(k))
        pmu_q[k] <= alias_op(op, pmu_q[k], bus_wdata);
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (id_hit) rd_next = ID_VALUE;
    for (int k = 0; k < ANA_N; k++)
      if (ana_hit && ana_off[AW-1:4] == (AW-4)'(k)) rd_next = ana_q[k];
    for (int k = 0; k < PMU_N; k++)
      if (pmu_hit && pmu_off[AW-1:4] == (AW-4)'(k)) rd_next = pmu_q[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data      <= '0;
      rd_valid     <= 1'b0;
      id_wr_reject <= 1'b0;
    end else begin
      rd_valid     <= rd;
      id_wr_reject <= wr && id_hit;
      if (rd) rd_data <= rd_next;
    end
endmodule

module sct_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [15:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        id_wr_reject,
  input logic [31:0] slot0
);
  wire rd = bus_valid && !bus_write;
  wire wr = bus_valid && bus_write;
  wire is_id = (bus_addr == 16'h0800);
  wire unmapped = (bus_addr[1:0] != 2'b00) ||
                  (!is_id && !((bus_addr >= 16'h0060 && bus_addr < 16'h0120) ||
                               (bus_addr >= 16'h0200 && bus_addr < 16'h0280)));

  a_r8_rd_valid: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rd_valid);
  a_r8_no_rd_valid: assert property (@(posedge clk) disable iff (!rst_n) !rd |=> !rd_valid);
  a_r5_id_value: assert property (@(posedge clk) disable iff (!rst_n) (rd && is_id) |=> rd_data == 32'h0072_0010);
  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n) (wr && is_id) |=> id_wr_reject);
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n) !(wr && is_id) |=> !id_wr_reject);
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n) (rd && unmapped) |=> rd_data == 32'h0);
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 16'h0064) |=> (slot0 & $past(bus_wdata)) == $past(bus_wdata));
  a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 16'h0068) |=> (slot0 & $past(bus_wdata)) == 32'h0);
endmodule

bind sct_regbank sct_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
  .rd_valid(rd_valid), .id_wr_reject(id_wr_reject), .slot0(ana_q[0])
);

// File: tb/sct_regbank_tb.sv
`timescale 1ns/1ps
module sct_regbank_tb;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid, id_wr_reject;
  int total = 0, bad = 0;
  bit done = 0;
  bit [31:0] ana [12];
  bit [31:0] pmu [8];

  always #2 clk = ~clk;

  sct_regbank u_dut (.clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
                     .rd_data, .rd_valid, .id_wr_reject);

  function automatic bit [31:0] init_val(int k);
    bit [31:0] v [8] = '{32'h0000_2042, 32'h0060_302C, 32'h0000_2000, 32'h5260_5A56,
                         32'h5252_5216, 32'h0000_1FC0, 32'h0001_301B, 32'h0008_201B};
    return (k < 8) ? (v[k] | 32'h8000_0000) : 32'h0;
  endfunction

  function automatic bit [31:0] op_val(bit [1:0] op, bit [31:0] c, bit [31:0] d);
    case (op)
      2'b00: return d;
      2'b01: return c | d;
      2'b10: return c & ~d;
      default: return c ^ d;
    endcase
  endfunction

  function automatic bit [31:0] model_rd(bit [15:0] a);
    if (a[1:0] != 0) return 0;
    if (a == 16'h0800) return 32'h0072_0010;
    if (a >= 16'h0060 && a < 16'h0120) return ana[(int'(a) - 'h60) / 16];
    if (a >= 16'h0200 && a < 16'h0280) return pmu[(int'(a) - 'h200) / 16];
    return 0;
  endfunction

  function automatic void model_wr(bit [15:0] a, bit [31:0] d);
    if (a[1:0] != 0 || a == 16'h0800) return;
    if (a >= 16'h0060 && a < 16'h0120) begin
      int i = (int'(a) - 'h60) / 16;
      ana[i] = op_val(a[3:2], ana[i], d);
    end else if (a >= 16'h0200 && a < 16'h0280) begin
      int i = (int'(a) - 'h200) / 16;
      pmu[i] = op_val(a[3:2], pmu[i], d);
    end
  endfunction

  task automatic check(bit ok, string tag, bit [31:0] act, bit [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic xfer(bit w, bit [15:0] a, bit [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic do_rd(bit [15:0] a, string tag);
    bit [31:0] e = model_rd(a);
    xfer(0, a, 0);
    check(rd_valid == 1, "R8 rd_valid", 32'(rd_valid), 1);
    check(rd_data == e, tag, rd_data, e);
  endtask

  task automatic do_wr(bit [15:0] a, bit [31:0] d, string tag);
    xfer(1, a, d);
    check(rd_valid == 0, "R8 no rd_valid on write", 32'(rd_valid), 0);
    check(id_wr_reject == (a == 16'h0800), {tag, " R6 reject"}, 32'(id_wr_reject), 32'(a == 16'h0800));
    model_wr(a, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 12; k++) ana[k] = init_val(k);
    for (int k = 0; k < 8; k++) pmu[k] = 0;
    repeat (3) @(negedge clk);
    check(rd_valid == 0 && id_wr_reject == 0, "reset outputs", {rd_valid, id_wr_reject}, 0);
    rst_n = 1;
    for (int k = 0; k < 12; k++) do_rd(16'(16'h60 + 16 * k), k < 8 ? "R1 reset clock value" : "R2 reset zero");
    for (int k = 0; k < 8; k++) do_rd(16'(16'h200 + 16 * k), "R2 reset zero pmu");
    do_wr(16'h0080, 32'h1234_5678, "R3 assign");
    do_rd(16'h0080, "R3 assign");
    do_wr(16'h0084, 32'h0000_00F0, "R3 set");
    do_rd(16'h0084, "R4 set alias read");
    do_wr(16'h0088, 32'h1200_0008, "R3 clear");
    do_rd(16'h0088, "R4 clear alias read");
    do_wr(16'h008C, 32'hFFFF_0000, "R3 toggle");
    do_rd(16'h008C, "R4 toggle alias read");
    do_rd(16'h0080, "R3 combined result");
    do_rd(16'h0800, "R5 id read");
    do_wr(16'h0800, 32'hFFFF_FFFF, "R5 id write");
    do_rd(16'h0800, "R5 id unchanged");
    do_wr(16'h0120, 32'hDEAD_BEEF, "R9 past group end");
    do_rd(16'h0120, "R9 past group end reads zero");
    do_rd(16'h0110, "R9 last slot mapped");
    do_wr(16'h0050, 32'hFFFF_FFFF, "R9 below group");
    do_rd(16'h0050, "R9 below group zero");
    do_wr(16'h0280, 32'h5555_5555, "R9 past pmu end");
    do_rd(16'h0280, "R9 past pmu end zero");
    do_wr(16'h0270, 32'h0BAD_F00D, "R9 last pmu slot");
    do_rd(16'h0274, "R9 last pmu slot");
    do_wr(16'h0062, 32'h0000_0000, "R7 misaligned write");
    do_rd(16'h0060, "R7 misaligned write ignored");
    do_rd(16'h0061, "R7 misaligned read zero");
    do_wr(16'h0300, 32'hFFFF_FFFF, "R7 unmapped write");
    do_rd(16'h0300, "R7 unmapped read zero");
    for (int k = 0; k < 12; k++) do_rd(16'(16'h60 + 16 * k), "R7 no register touched");
    for (int n = 0; n < 1500; n++) begin
      int cls = $urandom_range(0, 9);
      bit [15:0] a;
      bit [31:0] d = $urandom;
      bit w = $urandom_range(0, 1) == 1;
      bit [15:0] odd [8] = '{16'h0000, 16'h0020, 16'h0130, 16'h01F0, 16'h0300, 16'h07F0, 16'h0810, 16'hFFF0};
      case (cls)
        0, 1, 2, 3, 4: a = 16'(16'h60 + 16 * $urandom_range(0, 11) + 4 * $urandom_range(0, 3));
        5, 6: a = 16'(16'h200 + 16 * $urandom_range(0, 7) + 4 * $urandom_range(0, 3));
        7: a = 16'h0800;
        8: a = odd[$urandom_range(0, 7)];
        default: a = 16'(16'h60 + 16 * $urandom_range(0, 11) + $urandom_range(1, 3));
      endcase
      if (w) do_wr(a, d, "R3 random write");
      else do_rd(a, "R4 random read");
    end
    finish_run();
  end
endmodule